// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This block runs the ordinary load and store operations of a core whose register width is 32 or 64 bits. It adds a sign-extended 12-bit offset to a base register to form the effective address, then checks that the address is naturally aligned for the access size. It also checks that the access is legal for the register width. It drives a single-cycle memory port with the address, a byte count, a write enable and the store data. Store data is the low bytes of the source register, with the bits above them cleared.

The memory answers in the same cycle the request is presented. One clock later the unit reports a response: success or a fault code, and, for a successful load, a write-back of the loaded value. The loaded value is zero-extended or sign-extended to register width. A configuration input chooses whether a misaligned access traps or goes to memory unchanged. Fault sources are resolved in a fixed priority, and a memory request is issued only when no earlier check has failed.

Top module: `lsu_align_unit`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus `imm_i` sign-extended to XLEN bits, modulo 2^XLEN, in the same cycle.
- R2: Sizes are encoded in `size_i` as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An access is aligned when the address is a multiple of its byte count. When `misal_ok_i` is 1, a misaligned access is sent to memory like an aligned one.
- R3: When `misal_ok_i` is 0, a misaligned load reports fault 2 and a misaligned store reports fault 3. In both cases `mem_req_o` stays low.
- R4: On a successful load, `rd_data_o` holds the low bytes of `mem_rdata_i`. The upper bits are zero-filled when `is_unsigned_i` is 1 and filled with the loaded sign bit otherwise.
- R5: A load with `is_unsigned_i` set whose size in bits is not smaller than XLEN is illegal. So is any 8-byte access when XLEN is 32. An illegal access reports fault 6 and issues no memory request.
- R6: While `mem_req_o` is high, `mem_nbytes_o` equals 2^`size_i`. For a store, `mem_wdata_o` holds the low 8·2^`size_i` bits of `rs2_i` with every bit above them zero.
- R7: Fault codes follow this priority, first match wins: illegal (6), then `addr_chk_err_i` (1), then misaligned (2 or 3), then `xlate_err_i` (4), then `mem_err_i` (5). A result with no fault reports 0.
- R8: `rd_we_o` rises only in the response to a load that has fault 0. It never rises for a store.
- R9: A store whose memory access returns `mem_err_i` = 0 and `mem_done_i` = 0 reports fault 7 as an internal error.
- R10: Each cycle with `req_valid_i` high produces `rsp_valid_o` high one cycle later. After reset, `rsp_valid_o` and `rd_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Operation present this cycle |
| is_store_i | input | 1 | 1 = store, 0 = load |
| is_unsigned_i | input | 1 | Zero-extend load result |
| size_i | input | 2 | Access size code |
| base_i | input | XLEN | Base register value |
| imm_i | input | 12 | Signed offset |
| rs2_i | input | XLEN | Store source register |
| misal_ok_i | input | 1 | Platform allows misaligned access |
| addr_chk_err_i | input | 1 | Address extension check failed |
| xlate_err_i | input | 1 | Address translation failed |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | XLEN | Effective address |
| mem_nbytes_o | output | NBW | Access byte count |
| mem_wdata_o | output | XLEN | Truncated store data |
| mem_rdata_i | input | XLEN | Memory read data |
| mem_err_i | input | 1 | Memory access fault |
| mem_done_i | input | 1 | Store performed |
| rsp_valid_o | output | 1 | Response valid |
| rsp_fault_o | output | 3 | Fault code, 0 = success |
| rd_we_o | output | 1 | Destination write-back |
| rd_data_o | output | XLEN | Extended load data |

## Verification
The memory-port outputs (address, request, byte count, store data) depend only on the inputs of the same cycle. The bench drives each operation on a falling edge and checks the port two nanoseconds later, before the rising edge. The response, fault code and write-back data go through a single register stage. They are checked two nanoseconds after the next rising edge, in the same operation slot, before the next operation is driven on the following falling edge.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;
  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} lsu_size_e;
  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ADDR_CHK = 3'd1,
    FLT_LD_MISAL = 3'd2,
    FLT_ST_MISAL = 3'd3,
    FLT_XLATE    = 3'd4,
    FLT_MEM      = 3'd5,
    FLT_ILLEGAL  = 3'd6,
    FLT_INTERNAL = 3'd7
  } lsu_fault_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [11:0]     imm_i,
  input  lsu_size_e       size_i,
  output logic [XLEN-1:0] addr_o,
  output logic            aligned_o
);
  localparam int EXT_W = XLEN - 12;

  assign addr_o = base_i + {{EXT_W{imm_i[11]}}, imm_i};

  always_comb begin
    unique case (size_i)
      SZ_B: aligned_o = 1'b1;
      SZ_H: aligned_o = ~addr_o[0];
      SZ_W: aligned_o = addr_o[1:0] == 2'b00;
      default: aligned_o = addr_o[2:0] == 3'b000;
    endcase
  end
endmodule

// File: rtl/lsu_ld_fmt.sv
module lsu_ld_fmt
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw_i,
  input  lsu_size_e       size_i,
  input  logic            uns_i,
  output logic [XLEN-1:0] data_o
);
  int   msb;
  logic fill;

  always_comb begin
    msb  = (8 << size_i) - 1;
    fill = 1'b0;
    for (int i = 0; i < XLEN; i++)
      if (i == msb) fill = raw_i[i] & ~uns_i;
    for (int i = 0; i < XLEN; i++)
      data_o[i] = (i <= msb) ? raw_i[i] : fill;
  end
endmodule

// File: rtl/lsu_st_fmt.sv
module lsu_st_fmt
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NBW  = 4
) (
  input  logic [XLEN-1:0] rs2_i,
  input  lsu_size_e       size_i,
  output logic [XLEN-1:0] wdata_o,
  output logic [NBW-1:0]  nbytes_o
);
  int nbits;

  assign nbytes_o = NBW'(1) << size_i;

  always_comb begin
    nbits = 8 << size_i;
    for (int i = 0; i < XLEN; i++)
      wdata_o[i] = (i < nbits) ? rs2_i[i] : 1'b0;
  end
endmodule

// File: rtl/lsu_align_unit.sv
module lsu_align_unit
  import lsu_align_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int NBW = $clog2(XLEN / 8) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            is_store_i,
  input  logic            is_unsigned_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] base_i,
  input  logic [11:0]     imm_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic            misal_ok_i,
  input  logic            addr_chk_err_i,
  input  logic            xlate_err_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [NBW-1:0]  mem_nbytes_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  input  logic            mem_err_i,
  input  logic            mem_done_i,
  output logic            rsp_valid_o,
  output logic [2:0]      rsp_fault_o,
  output logic            rd_we_o,
  output logic [XLEN-1:0] rd_data_o
);
  lsu_size_e       size;
  logic            aligned, illegal, misal_trap;
  logic [XLEN-1:0] ld_data;
  lsu_fault_e      fault_c;
  logic            st_q;

  assign size = lsu_size_e'(size_i);

  lsu_agen #(.XLEN(XLEN)) u_agen (
    .base_i(base_i), .imm_i(imm_i), .size_i(size),
    .addr_o(mem_addr_o), .aligned_o(aligned)
  );

  lsu_st_fmt #(.XLEN(XLEN), .NBW(NBW)) u_st_fmt (
    .rs2_i(rs2_i), .size_i(size), .wdata_o(mem_wdata_o), .nbytes_o(mem_nbytes_o)
  );

  lsu_ld_fmt #(.XLEN(XLEN)) u_ld_fmt (
    .raw_i(mem_rdata_i), .size_i(size), .uns_i(is_unsigned_i), .data_o(ld_data)
  );

  // decode legality: unsigned load only below register width
  assign illegal = (size == SZ_D && XLEN < 64) ||
                   (!is_store_i && is_unsigned_i && (8 << size_i) >= XLEN);
  assign misal_trap = !aligned && !misal_ok_i;

  assign mem_req_o = req_valid_i && !illegal && !addr_chk_err_i && !misal_trap && !xlate_err_i;
  assign mem_we_o  = is_store_i;

  always_comb begin
    if (illegal)                       fault_c = FLT_ILLEGAL;
    else if (addr_chk_err_i)           fault_c = FLT_ADDR_CHK;
    else if (misal_trap)               fault_c = is_store_i ? FLT_ST_MISAL : FLT_LD_MISAL;
    else if (xlate_err_i)              fault_c = FLT_XLATE;
    else if (mem_err_i)                fault_c = FLT_MEM;
    else if (is_store_i && !mem_done_i) fault_c = FLT_INTERNAL;
    else                               fault_c = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 3'd0;
      rd_we_o     <= 1'b0;
      rd_data_o   <= '0;
      st_q        <= 1'b0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_fault_o <= req_valid_i ? fault_c : 3'd0;
      rd_we_o     <= req_valid_i && !is_store_i && fault_c == FLT_NONE;
      st_q        <= is_store_i;
      if (req_valid_i && !is_store_i && fault_c == FLT_NONE) rd_data_o <= ld_data;
    end
  end

  assert_rsp_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_no_mem_on_misal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !aligned && !misal_ok_i) |-> !mem_req_o);
  assert_wb_only_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rsp_valid_o && rsp_fault_o == 3'd0 && !st_q));
  assert_nbytes_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $countones(mem_nbytes_o) == 1);
  assert_illegal_no_mem_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && illegal) |-> !mem_req_o);
endmodule

// File: tb/sim_lsu_align_unit.sv
`timescale 1ns/1ps
module sim_lsu_align_unit;
  localparam int XLEN = 64;
  localparam int NBW  = 4;

  logic            clk = 0, rst_ni = 0;
  logic            req_valid_i = 0, is_store_i = 0, is_unsigned_i = 0;
  logic [1:0]      size_i = 0;
  logic [XLEN-1:0] base_i = 0, rs2_i = 0, mem_rdata_i = 0;
  logic [11:0]     imm_i = 0;
  logic            misal_ok_i = 0, addr_chk_err_i = 0, xlate_err_i = 0;
  logic            mem_err_i = 0, mem_done_i = 1;
  logic            mem_req_o, mem_we_o, rsp_valid_o, rd_we_o;
  logic [XLEN-1:0] mem_addr_o, mem_wdata_o, rd_data_o;
  logic [NBW-1:0]  mem_nbytes_o;
  logic [2:0]      rsp_fault_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lsu_align_unit #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .is_store_i(is_store_i),
    .is_unsigned_i(is_unsigned_i), .size_i(size_i), .base_i(base_i), .imm_i(imm_i),
    .rs2_i(rs2_i), .misal_ok_i(misal_ok_i), .addr_chk_err_i(addr_chk_err_i),
    .xlate_err_i(xlate_err_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_nbytes_o(mem_nbytes_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_err_i(mem_err_i), .mem_done_i(mem_done_i),
    .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o), .rd_we_o(rd_we_o),
    .rd_data_o(rd_data_o)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] low_mask(logic [1:0] sz);
    return (sz == 2'd3) ? '1 : ((64'd1 << (8 << sz)) - 1);
  endfunction

  function automatic logic [63:0] ext_ld(logic [63:0] raw, logic [1:0] sz, logic uns);
    logic [63:0] m = low_mask(sz);
    logic sb = raw[(8 << sz) - 1];
    return (raw & m) | ((!uns && sb) ? ~m : 64'd0);
  endfunction

  function automatic logic is_al(logic [63:0] a, logic [1:0] sz);
    return (a & ((64'd1 << sz) - 1)) == 0;
  endfunction

  function automatic logic [2:0] exp_fault(logic st, logic uns, logic [1:0] sz, logic [63:0] a,
      logic mok, logic ace, logic xe, logic me, logic done);
    if (!st && uns && (8 << sz) >= XLEN) return 3'd6;
    if (ace) return 3'd1;
    if (!is_al(a, sz) && !mok) return st ? 3'd3 : 3'd2;
    if (xe) return 3'd4;
    if (me) return 3'd5;
    if (st && !done) return 3'd7;
    return 3'd0;
  endfunction

  task automatic run_op(string tag, logic st, logic uns, logic [1:0] sz, logic [63:0] base,
      logic [11:0] imm, logic [63:0] rs2, logic mok, logic ace, logic xe, logic me,
      logic done, logic [63:0] rdat);
    logic [63:0] ea;
    logic [2:0]  f;
    logic        mreq;
    @(negedge clk);
    req_valid_i = 1; is_store_i = st; is_unsigned_i = uns; size_i = sz; base_i = base;
    imm_i = imm; rs2_i = rs2; misal_ok_i = mok; addr_chk_err_i = ace; xlate_err_i = xe;
    mem_err_i = me; mem_done_i = done; mem_rdata_i = rdat;
    ea = base + {{52{imm[11]}}, imm};
    f = exp_fault(st, uns, sz, ea, mok, ace, xe, me, done);
    mreq = (f == 3'd0 || f == 3'd5 || f == 3'd7);
    #2;
    chk("R1 addr", mem_addr_o, ea);
    chk({tag, " mem_req"}, {63'd0, mem_req_o}, {63'd0, mreq});
    if (mreq) begin
      chk("R6 nbytes", {60'd0, mem_nbytes_o}, 64'd1 << sz);
      if (st) chk("R6 wdata", mem_wdata_o, rs2 & low_mask(sz));
    end
    @(posedge clk); #2;
    chk("R10 rsp_valid", {63'd0, rsp_valid_o}, 64'd1);
    chk({tag, " fault"}, {61'd0, rsp_fault_o}, {61'd0, f});
    chk("R8 rd_we", {63'd0, rd_we_o}, {63'd0, (!st && f == 3'd0)});
    if (!st && f == 3'd0) chk("R4 rd_data", rd_data_o, ext_ld(rdat, sz, uns));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    #35;
    chk("R10 reset rsp_valid", {63'd0, rsp_valid_o}, 64'd0);
    chk("R10 reset rd_we", {63'd0, rd_we_o}, 64'd0);
    rst_ni = 1;
    // directed corners
    run_op("R1", 0, 0, 2'd2, 64'h1000, 12'hFFC, 0, 0, 0, 0, 0, 1, 64'h0000_0000_8000_0001);
    run_op("R4", 0, 1, 2'd0, 64'h20, 12'h001, 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FF80);
    run_op("R4", 0, 0, 2'd1, 64'h20, 12'h002, 0, 0, 0, 0, 0, 1, 64'h0000_0000_0000_8001);
    run_op("R3", 0, 0, 2'd2, 64'h22, 12'h000, 0, 0, 0, 0, 0, 1, 64'h0);
    run_op("R3", 1, 0, 2'd3, 64'h24, 12'h000, 64'h1234, 0, 0, 0, 0, 1, 64'h0);
    run_op("R2", 0, 0, 2'd3, 64'h23, 12'h000, 0, 1, 0, 0, 0, 1, 64'h8123_4567_89AB_CDEF);
    run_op("R5", 0, 1, 2'd3, 64'h40, 12'h000, 0, 0, 1, 1, 1, 1, 64'h0);
    run_op("R7", 0, 0, 2'd2, 64'h41, 12'h000, 0, 0, 1, 1, 1, 1, 64'h0);
    run_op("R7", 1, 0, 2'd2, 64'h41, 12'h000, 0, 0, 0, 1, 1, 1, 64'h0);
    run_op("R7", 0, 0, 2'd2, 64'h40, 12'h000, 0, 0, 0, 1, 1, 1, 64'h0);
    run_op("R7", 0, 0, 2'd2, 64'h40, 12'h000, 0, 0, 0, 0, 1, 1, 64'h0);
    run_op("R9", 1, 0, 2'd1, 64'h40, 12'h000, 64'hABCD_EF01, 0, 0, 0, 0, 0, 64'h0);
    run_op("R6", 1, 1, 2'd0, 64'h7FF, 12'h801, 64'hFFFF_FFFF_FFFF_FFA5, 0, 0, 0, 0, 1, 64'h0);
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] b;
      logic [1:0]  sz;
      sz = 2'($urandom_range(0, 3));
      b = {$urandom, $urandom};
      if ($urandom_range(0, 3) != 0) b[2:0] = 3'b000;
      run_op("R7", 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), sz, b,
             12'($urandom), {$urandom, $urandom}, 1'($urandom_range(0, 1)),
             $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
             $urandom_range(0, 15) == 0, $urandom_range(0, 15) != 0, {$urandom, $urandom});
    end
    @(negedge clk);
    req_valid_i = 0;
    @(posedge clk); #2;
    chk("R10 idle", {63'd0, rsp_valid_o}, 64'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule